// File: doc/BRIEF.md
# Instruction Decoder with Legality and Privilege Checking

This block is a purely combinational decoder for a 32-bit load/store integer instruction word. It sorts the word into one of twelve encoding groups. For that group it produces the controls the execute stage needs:

- the ALU operation,
- the immediate format and the sign-extended immediate,
- the memory access direction, size and signedness,
- the branch condition,
- a jump flag,
- the system or custom operation,
- the CSR address for CSR operations,
- a request to flush the translation buffers.

Only an explicit list of opcode and function combinations is accepted. Every other word raises `illegal_o`. The multiply, atomic, compressed and floating-point encodings are all illegal.

A one-bit privilege input tells the decoder whether the hart runs in supervisor mode. Operations reserved for supervisor mode are rejected when that input is low. These are the CSR operations, trap return and memory wipe.

When a word is rejected, every control output goes to its idle value. Downstream logic then only needs `illegal_o` to raise a trap. The register index fields are passed through unchanged in all cases.

Top module: `insn_decoder`

## Requirements
- R1: `grp_o` encodes the group from bits 6:0 as follows:
  - 0000011 → 1 (load)
  - 0001111 → 2 (fence)
  - 0010011 → 3 (op-imm)
  - 0010111 → 4 (auipc)
  - 0100011 → 5 (store)
  - 0110011 → 6 (op)
  - 0110111 → 7 (lui)
  - 1100011 → 8 (branch)
  - 1100111 → 9 (jalr)
  - 1101111 → 10 (jal)
  - 1110011 → 11 (system)
  - 0001011 → 12 (custom)

  Any other opcode, including all words with bits 1:0 not equal to 11, sets `illegal_o`.
- R2: In group 6, bits 31:25 = 0000000 give `alu_op_o` by bits 14:12 as follows: 000→1 ADD, 001→3 SLL, 010→4 SLT, 011→5 SLTU, 100→6 XOR, 101→7 SRL, 110→9 OR, 111→10 AND. Bits 31:25 = 0100000 give SUB (2) with bits 14:12 = 000 and SRA (8) with 101. Every other bits 31:25 / bits 14:12 pair is illegal, including 0000001.
- R3: In group 3, bits 14:12 select ALU codes as in R2 (000 ADD, 010 SLT, 011 SLTU, 100 XOR, 110 OR, 111 AND). Code 001 (SLL) requires bits 31:25 = 0. Code 101 gives SRL with bits 31:25 = 0000000 and SRA with 0100000; any other bits 31:25 value is illegal. The 5-bit shift amount appears in `imm_o[4:0]`.
- R4: `imm_fmt_o` and `imm_o` take these values:

  | Format | `imm_fmt_o` | `imm_o` |
  |---|---|---|
  | I | 1 | sext(w[31:20]) |
  | S | 2 | sext({w[31:25], w[11:7]}) |
  | B | 3 | sext({w[31], w[7], w[30:25], w[11:8], 0}) |
  | U | 4 | {w[31:12], 12'b0} |
  | J | 5 | sext({w[31], w[19:12], w[20], w[30:21], 0}) |

  Load, op-imm and jalr use I. Store uses S, branch uses B, lui and auipc use U, and jal uses J. All other groups give format 0 and immediate 0.
- R5: Loads use bits 14:12 as follows: 000, 001 and 010 are byte, half and word signed; 100 and 101 are byte and half unsigned. `mem_size_o` is bits 13:12 and `mem_uns_o` is bit 14. Stores accept 000, 001 and 010 only, with `mem_uns_o` = 0. `mem_rd_o` is set for loads and `mem_wr_o` for stores. Any other code in either group is illegal.
- R6: Branches map bits 14:12 to `br_o` as follows: 000→1 EQ, 001→2 NE, 100→3 LT, 101→4 GE, 110→5 LTU, 111→6 GEU. Codes 010 and 011 are illegal. Jalr is legal only with bits 14:12 = 000. `jump_o` is set for jal and jalr.
- R7: In the system group, the exact words below are legal:
  - 0x00000073 gives `sys_o` = 1 (environment call).
  - 0x00100073 gives 2 (breakpoint).
  - 0x10200073 gives 3 (trap return).

  Bits 14:12 = 001, 010 and 011 give CSR write (4), set (5) and clear (6), with `csr_addr_o` = bits 31:20. Every other system word is illegal.
- R8: When `priv_s_i` = 0, trap return, the three CSR operations and memory wipe set `illegal_o`. With `priv_s_i` = 1 the same words are legal.
- R9: In the custom group, bits 14:12 map to `sys_o` as follows: 000 → 7 (zero destination register), 001 → 8 (memory wipe), 010 → 9 (random read). Other codes are illegal. Bits 31:25 have no effect on any output.
- R10: In the fence group, bits 14:12 = 000 give `sys_o` = 10. Bits 14:12 = 001 give `sys_o` = 11 (instruction-fetch fence) with `tlb_flush_o` = 1. Other codes are illegal. `tlb_flush_o` is 0 for every other word.
- R11: When `illegal_o` = 1, all of the following are 0: `grp_o`, `alu_op_o`, `imm_fmt_o`, `imm_o`, `mem_rd_o`, `mem_wr_o`, `mem_size_o`, `mem_uns_o`, `br_o`, `jump_o`, `sys_o`, `csr_addr_o` and `tlb_flush_o`.
- R12: `alu_op_o` is 11 (pass immediate) for lui. It is 1 (ADD) for auipc, jal, jalr, loads and stores. It is 0 for branch, fence, system and custom.
- R13: `rd_o`, `rs1_o` and `rs2_o` always equal bits 11:7, 19:15 and 24:20, legal or not.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| insn_i | input | 32 | Instruction word |
| priv_s_i | input | 1 | 1 = supervisor mode, 0 = user mode |
| grp_o | output | 4 | Encoding group code |
| alu_op_o | output | 4 | ALU operation code |
| imm_fmt_o | output | 3 | Immediate format code |
| imm_o | output | 32 | Sign-extended immediate |
| mem_rd_o | output | 1 | Memory read |
| mem_wr_o | output | 1 | Memory write |
| mem_size_o | output | 2 | 0 byte, 1 half, 2 word |
| mem_uns_o | output | 1 | Zero-extend load data |
| br_o | output | 3 | Branch condition code |
| jump_o | output | 1 | Unconditional jump |
| sys_o | output | 4 | System or custom operation code |
| csr_addr_o | output | 12 | CSR address for CSR operations |
| tlb_flush_o | output | 1 | Translation buffer flush request |
| illegal_o | output | 1 | Illegal instruction |
| rd_o | output | 5 | Destination register field |
| rs1_o | output | 5 | First source register field |
| rs2_o | output | 5 | Second source register field |

## Verification
Random words are built by placing one of the twelve legal opcodes under random other bits. Bits 31:25 are biased toward 0000000, 0100000 and 0000001, so that ADD/SUB, SRL/SRA and the rejected multiply space are all told apart. Fully random words, with most bits 1:0 patterns, exercise the unlisted-opcode and compressed rejection. Directed words cover:
- the three exact system encodings and their one-bit neighbours, under both privilege levels, which separates the privilege rule from the encoding rule;
- custom words with reserved bits set, to show those bits are ignored;
- immediates with the sign bit set in every format, so that bit-scatter errors become visible.

// File: rtl/dec_pkg.sv
package dec_pkg;
    localparam int ILEN = 32;
    localparam int REGW = 5;
    localparam int CSRW = 12;
    localparam int OPCW = 7;

    localparam logic [ILEN-1:0] W_ECALL  = 32'h0000_0073;
    localparam logic [ILEN-1:0] W_EBREAK = 32'h0010_0073;
    localparam logic [ILEN-1:0] W_TRET   = 32'h1020_0073;

    typedef enum logic [3:0] {
        G_BAD = 4'd0, G_LOAD = 4'd1, G_FENCE = 4'd2, G_OPIMM = 4'd3,
        G_AUIPC = 4'd4, G_STORE = 4'd5, G_OP = 4'd6, G_LUI = 4'd7,
        G_BRANCH = 4'd8, G_JALR = 4'd9, G_JAL = 4'd10, G_SYSTEM = 4'd11,
        G_CUSTOM = 4'd12
    } grp_e;

    typedef enum logic [3:0] {
        A_NONE = 4'd0, A_ADD = 4'd1, A_SUB = 4'd2, A_SLL = 4'd3, A_SLT = 4'd4,
        A_SLTU = 4'd5, A_XOR = 4'd6, A_SRL = 4'd7, A_SRA = 4'd8, A_OR = 4'd9,
        A_AND = 4'd10, A_PASS = 4'd11
    } alu_e;

    typedef enum logic [2:0] {
        F_NONE = 3'd0, F_I = 3'd1, F_S = 3'd2, F_B = 3'd3, F_U = 3'd4, F_J = 3'd5
    } fmt_e;

    typedef enum logic [2:0] {
        B_NONE = 3'd0, B_EQ = 3'd1, B_NE = 3'd2, B_LT = 3'd3,
        B_GE = 3'd4, B_LTU = 3'd5, B_GEU = 3'd6
    } br_e;

    typedef enum logic [3:0] {
        S_NONE = 4'd0, S_ECALL = 4'd1, S_EBREAK = 4'd2, S_TRET = 4'd3,
        S_CSRW = 4'd4, S_CSRS = 4'd5, S_CSRC = 4'd6, S_ZERO = 4'd7,
        S_WIPE = 4'd8, S_RAND = 4'd9, S_FENCE = 4'd10, S_FLUSH = 4'd11
    } sys_e;

    function automatic alu_e base_alu(input logic [2:0] f3);
        unique case (f3)
            3'b000:  return A_ADD;
            3'b001:  return A_SLL;
            3'b010:  return A_SLT;
            3'b011:  return A_SLTU;
            3'b100:  return A_XOR;
            3'b101:  return A_SRL;
            3'b110:  return A_OR;
            default: return A_AND;
        endcase
    endfunction
endpackage

// File: rtl/dec_major.sv
module dec_major
    import dec_pkg::*;
(
    input  logic [OPCW-1:0] opc_i,
    output grp_e            grp_o,
    output fmt_e            fmt_o
);
    always_comb begin
        grp_o = G_BAD;
        fmt_o = F_NONE;
        unique case (opc_i)
            7'b0000011: begin grp_o = G_LOAD;   fmt_o = F_I; end
            7'b0001111: begin grp_o = G_FENCE;  fmt_o = F_NONE; end
            7'b0010011: begin grp_o = G_OPIMM;  fmt_o = F_I; end
            7'b0010111: begin grp_o = G_AUIPC;  fmt_o = F_U; end
            7'b0100011: begin grp_o = G_STORE;  fmt_o = F_S; end
            7'b0110011: begin grp_o = G_OP;     fmt_o = F_NONE; end
            7'b0110111: begin grp_o = G_LUI;    fmt_o = F_U; end
            7'b1100011: begin grp_o = G_BRANCH; fmt_o = F_B; end
            7'b1100111: begin grp_o = G_JALR;   fmt_o = F_I; end
            7'b1101111: begin grp_o = G_JAL;    fmt_o = F_J; end
            7'b1110011: begin grp_o = G_SYSTEM; fmt_o = F_NONE; end
            7'b0001011: begin grp_o = G_CUSTOM; fmt_o = F_NONE; end
            default:    begin grp_o = G_BAD;    fmt_o = F_NONE; end
        endcase
    end
endmodule

// File: rtl/dec_imm.sv
module dec_imm
    import dec_pkg::*;
(
    input  logic [ILEN-1:0] insn_i,
    input  fmt_e            fmt_i,
    output logic [ILEN-1:0] imm_o
);
    logic sgn;
    assign sgn = insn_i[ILEN-1];

    always_comb begin
        unique case (fmt_i)
            F_I: imm_o = {{(ILEN-12){sgn}}, insn_i[31:20]};
            F_S: imm_o = {{(ILEN-12){sgn}}, insn_i[31:25], insn_i[11:7]};
            F_B: imm_o = {{(ILEN-13){sgn}}, insn_i[31], insn_i[7],
                          insn_i[30:25], insn_i[11:8], 1'b0};
            F_U: imm_o = {insn_i[31:12], 12'b0};
            F_J: imm_o = {{(ILEN-21){sgn}}, insn_i[31], insn_i[19:12],
                          insn_i[20], insn_i[30:21], 1'b0};
            default: imm_o = '0;
        endcase
    end
endmodule

// File: rtl/dec_func.sv
module dec_func
    import dec_pkg::*;
(
    input  logic [ILEN-1:0] insn_i,
    input  grp_e            grp_i,
    output alu_e            alu_o,
    output br_e             br_o,
    output sys_e            sys_o,
    output logic            mem_rd_o,
    output logic            mem_wr_o,
    output logic [1:0]      size_o,
    output logic            uns_o,
    output logic            jump_o,
    output logic            csr_o,
    output logic            legal_o,
    output logic            sup_o
);
    logic [2:0] f3;
    logic [6:0] f7;
    assign f3 = insn_i[14:12];
    assign f7 = insn_i[31:25];

    always_comb begin
        alu_o = A_NONE;   br_o = B_NONE;   sys_o = S_NONE;
        mem_rd_o = 1'b0;  mem_wr_o = 1'b0; size_o = 2'd0;  uns_o = 1'b0;
        jump_o = 1'b0;    csr_o = 1'b0;    legal_o = 1'b0; sup_o = 1'b0;
        unique case (grp_i)
            G_LOAD: begin
                legal_o  = (f3 != 3'b011) && (f3 < 3'b110);
                mem_rd_o = 1'b1;
                size_o   = f3[1:0];
                uns_o    = f3[2];
                alu_o    = A_ADD;
            end
            G_STORE: begin
                legal_o  = (f3 < 3'b011);
                mem_wr_o = 1'b1;
                size_o   = f3[1:0];
                alu_o    = A_ADD;
            end
            G_BRANCH: begin
                legal_o = (f3[2:1] != 2'b01);
                unique case (f3)
                    3'b000:  br_o = B_EQ;
                    3'b001:  br_o = B_NE;
                    3'b100:  br_o = B_LT;
                    3'b101:  br_o = B_GE;
                    3'b110:  br_o = B_LTU;
                    3'b111:  br_o = B_GEU;
                    default: br_o = B_NONE;
                endcase
            end
            G_JALR: begin
                legal_o = (f3 == 3'b000);
                alu_o   = A_ADD;
                jump_o  = 1'b1;
            end
            G_JAL: begin
                legal_o = 1'b1;
                alu_o   = A_ADD;
                jump_o  = 1'b1;
            end
            G_LUI: begin
                legal_o = 1'b1;
                alu_o   = A_PASS;
            end
            G_AUIPC: begin
                legal_o = 1'b1;
                alu_o   = A_ADD;
            end
            G_OP: begin
                unique case (f7)
                    7'b0000000: begin legal_o = 1'b1; alu_o = base_alu(f3); end
                    7'b0100000: begin
                        if (f3 == 3'b000) begin
                            legal_o = 1'b1; alu_o = A_SUB;
                        end else if (f3 == 3'b101) begin
                            legal_o = 1'b1; alu_o = A_SRA;
                        end
                    end
                    default: legal_o = 1'b0;
                endcase
            end
            G_OPIMM: begin
                unique case (f3)
                    3'b001: begin
                        legal_o = (f7 == 7'b0000000);
                        alu_o   = A_SLL;
                    end
                    3'b101: begin
                        if (f7 == 7'b0000000) begin
                            legal_o = 1'b1; alu_o = A_SRL;
                        end else if (f7 == 7'b0100000) begin
                            legal_o = 1'b1; alu_o = A_SRA;
                        end
                    end
                    default: begin legal_o = 1'b1; alu_o = base_alu(f3); end
                endcase
            end
            G_FENCE: begin
                if (f3 == 3'b000) begin
                    legal_o = 1'b1; sys_o = S_FENCE;
                end else if (f3 == 3'b001) begin
                    legal_o = 1'b1; sys_o = S_FLUSH;
                end
            end
            G_SYSTEM: begin
                if (insn_i == W_ECALL) begin
                    legal_o = 1'b1; sys_o = S_ECALL;
                end else if (insn_i == W_EBREAK) begin
                    legal_o = 1'b1; sys_o = S_EBREAK;
                end else if (insn_i == W_TRET) begin
                    legal_o = 1'b1; sys_o = S_TRET; sup_o = 1'b1;
                end else begin
                    unique case (f3)
                        3'b001:  begin legal_o = 1'b1; sys_o = S_CSRW; end
                        3'b010:  begin legal_o = 1'b1; sys_o = S_CSRS; end
                        3'b011:  begin legal_o = 1'b1; sys_o = S_CSRC; end
                        default: legal_o = 1'b0;
                    endcase
                    csr_o = legal_o;
                    sup_o = 1'b1;
                end
            end
            G_CUSTOM: begin
                unique case (f3)
                    3'b000:  begin legal_o = 1'b1; sys_o = S_ZERO; end
                    3'b001:  begin legal_o = 1'b1; sys_o = S_WIPE; sup_o = 1'b1; end
                    3'b010:  begin legal_o = 1'b1; sys_o = S_RAND; end
                    default: legal_o = 1'b0;
                endcase
            end
            default: legal_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/insn_decoder.sv
module insn_decoder
    import dec_pkg::*;
(
    input  logic [31:0] insn_i,
    input  logic        priv_s_i,
    output logic [3:0]  grp_o,
    output logic [3:0]  alu_op_o,
    output logic [2:0]  imm_fmt_o,
    output logic [31:0] imm_o,
    output logic        mem_rd_o,
    output logic        mem_wr_o,
    output logic [1:0]  mem_size_o,
    output logic        mem_uns_o,
    output logic [2:0]  br_o,
    output logic        jump_o,
    output logic [3:0]  sys_o,
    output logic [11:0] csr_addr_o,
    output logic        tlb_flush_o,
    output logic        illegal_o,
    output logic [4:0]  rd_o,
    output logic [4:0]  rs1_o,
    output logic [4:0]  rs2_o
);
    grp_e            grp;
    fmt_e            fmt;
    alu_e            alu;
    br_e             br;
    sys_e            sys;
    logic [ILEN-1:0] imm;
    logic            mrd, mwr, uns, jmp, csr_v, legal, sup;
    logic [1:0]      size;
    logic            ok;

    dec_major u_major (.opc_i(insn_i[OPCW-1:0]), .grp_o(grp), .fmt_o(fmt));

    dec_imm u_imm (.insn_i(insn_i), .fmt_i(fmt), .imm_o(imm));

    dec_func u_func (
        .insn_i(insn_i), .grp_i(grp), .alu_o(alu), .br_o(br), .sys_o(sys),
        .mem_rd_o(mrd), .mem_wr_o(mwr), .size_o(size), .uns_o(uns),
        .jump_o(jmp), .csr_o(csr_v), .legal_o(legal), .sup_o(sup)
    );

    assign ok          = legal & (~sup | priv_s_i);
    assign illegal_o   = ~ok;
    assign grp_o       = ok ? grp : G_BAD;
    assign alu_op_o    = ok ? alu : A_NONE;
    assign imm_fmt_o   = ok ? fmt : F_NONE;
    assign imm_o       = ok ? imm : '0;
    assign mem_rd_o    = ok & mrd;
    assign mem_wr_o    = ok & mwr;
    assign mem_size_o  = ok ? size : 2'd0;
    assign mem_uns_o   = ok & uns;
    assign br_o        = ok ? br : B_NONE;
    assign jump_o      = ok & jmp;
    assign sys_o       = ok ? sys : S_NONE;
    assign csr_addr_o  = (ok & csr_v) ? insn_i[31:20] : '0;
    assign tlb_flush_o = ok & (sys == S_FLUSH);
    assign rd_o        = insn_i[11:7];
    assign rs1_o       = insn_i[19:15];
    assign rs2_o       = insn_i[24:20];

    always_comb begin
        if (!(insn_i[6:0] inside {7'b0000011, 7'b0001111, 7'b0010011, 7'b0010111,
                                  7'b0100011, 7'b0110011, 7'b0110111, 7'b1100011,
                                  7'b1100111, 7'b1101111, 7'b1110011, 7'b0001011}))
            AST_BAD_OPCODE: assert (illegal_o) else $error("unlisted opcode accepted"); // R1
        if (alu_op_o == 4'd2)
            AST_SUB_FIELD: assert (insn_i[30] && insn_i[6:0] == 7'b0110011) else $error("SUB without marker"); // R2
        AST_MEM_EXCL: assert (!(mem_rd_o && mem_wr_o)) else $error("read and write together"); // R5
        if (!priv_s_i && insn_i == W_TRET)
            AST_USER_TRET: assert (illegal_o) else $error("trap return in user mode"); // R8
        if (tlb_flush_o)
            AST_FLUSH_SRC: assert (insn_i[6:0] == 7'b0001111 && insn_i[14:12] == 3'b001)
                else $error("flush from wrong word"); // R10
        if (illegal_o)
            AST_ILL_NOJUMP: assert (!jump_o && br_o == 3'd0) else $error("control on illegal"); // R11
    end
endmodule

// File: tb/insn_decoder_bench.sv
module insn_decoder_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] insn = 32'h0;
    logic        priv = 1'b0;
    int          n_chk = 0;
    int          n_bad = 0;
    bit          done = 1'b0;

    logic [3:0]  grp_o, alu_op_o, sys_o;
    logic [2:0]  imm_fmt_o, br_o;
    logic [31:0] imm_o;
    logic        mem_rd_o, mem_wr_o, mem_uns_o, jump_o, tlb_flush_o, illegal_o;
    logic [1:0]  mem_size_o;
    logic [11:0] csr_addr_o;
    logic [4:0]  rd_o, rs1_o, rs2_o;

    always #4 clk = ~clk;

    insn_decoder u_insn_decoder (
        .insn_i(insn), .priv_s_i(priv), .grp_o(grp_o), .alu_op_o(alu_op_o),
        .imm_fmt_o(imm_fmt_o), .imm_o(imm_o), .mem_rd_o(mem_rd_o), .mem_wr_o(mem_wr_o),
        .mem_size_o(mem_size_o), .mem_uns_o(mem_uns_o), .br_o(br_o), .jump_o(jump_o),
        .sys_o(sys_o), .csr_addr_o(csr_addr_o), .tlb_flush_o(tlb_flush_o),
        .illegal_o(illegal_o), .rd_o(rd_o), .rs1_o(rs1_o), .rs2_o(rs2_o)
    );

    // expected vector: grp,alu,fmt,imm,mrd,mwr,size,uns,br,jump,sys,csr,flush,ill
    function automatic logic [69:0] model(input logic [31:0] w, input logic p);
        logic [3:0] g = 0, a = 0, s = 0;
        logic [2:0] f = 0, b = 0;
        logic [31:0] im = 0;
        logic mr = 0, mw = 0, un = 0, j = 0, fl = 0, ok = 0, sup = 0;
        logic [1:0] sz = 0;
        logic [11:0] ca = 0;
        logic [2:0] f3 = w[14:12];
        logic [6:0] f7 = w[31:25];
        logic [31:0] ii = {{20{w[31]}}, w[31:20]};
        case (w[6:0])
            7'b0000011: if (f3 inside {0, 1, 2, 4, 5}) begin
                ok = 1; g = 1; a = 1; f = 1; im = ii; mr = 1; sz = f3[1:0]; un = f3[2]; end
            7'b0100011: if (f3 < 3) begin
                ok = 1; g = 5; a = 1; f = 2; im = {{20{w[31]}}, w[31:25], w[11:7]}; mw = 1; sz = f3[1:0]; end
            7'b1100011: if (!(f3 inside {2, 3})) begin
                ok = 1; g = 8; f = 3; im = {{19{w[31]}}, w[31], w[7], w[30:25], w[11:8], 1'b0};
                b = (f3 == 0) ? 1 : (f3 == 1) ? 2 : 3'(f3 - 1); end
            7'b1100111: if (f3 == 0) begin ok = 1; g = 9; a = 1; f = 1; im = ii; j = 1; end
            7'b1101111: begin ok = 1; g = 10; a = 1; f = 5; j = 1;
                im = {{11{w[31]}}, w[31], w[19:12], w[20], w[30:21], 1'b0}; end
            7'b0110111: begin ok = 1; g = 7; a = 11; f = 4; im = {w[31:12], 12'h0}; end
            7'b0010111: begin ok = 1; g = 4; a = 1; f = 4; im = {w[31:12], 12'h0}; end
            7'b0110011: begin
                g = 6;
                if (f7 == 0) begin ok = 1; a = (f3 == 0) ? 1 : (f3 == 5) ? 7 : (f3 >= 6) ? 4'(f3 + 3) : 4'(f3 + 2); end
                else if (f7 == 7'h20 && f3 == 0) begin ok = 1; a = 2; end
                else if (f7 == 7'h20 && f3 == 5) begin ok = 1; a = 8; end
            end
            7'b0010011: begin
                g = 3; f = 1; im = ii;
                if (f3 == 1) begin ok = (f7 == 0); a = 3; end
                else if (f3 == 5) begin
                    if (f7 == 0) begin ok = 1; a = 7; end
                    else if (f7 == 7'h20) begin ok = 1; a = 8; end
                end else begin ok = 1; a = (f3 == 0) ? 1 : (f3 >= 6) ? 4'(f3 + 3) : 4'(f3 + 2); end
            end
            7'b0001111: begin
                g = 2;
                if (f3 == 0) begin ok = 1; s = 10; end
                else if (f3 == 1) begin ok = 1; s = 11; fl = 1; end
            end
            7'b1110011: begin
                g = 11;
                if (w == 32'h73) begin ok = 1; s = 1; end
                else if (w == 32'h0010_0073) begin ok = 1; s = 2; end
                else if (w == 32'h1020_0073) begin ok = 1; s = 3; sup = 1; end
                else if (f3 inside {1, 2, 3}) begin ok = 1; s = 4'(f3 + 3); sup = 1; ca = w[31:20]; end
            end
            7'b0001011: begin
                g = 12;
                if (f3 == 0) begin ok = 1; s = 7; end
                else if (f3 == 1) begin ok = 1; s = 8; sup = 1; end
                else if (f3 == 2) begin ok = 1; s = 9; end
            end
            default: ok = 0;
        endcase
        if (sup && !p) ok = 0;
        if (!ok) return {69'h0, 1'b1};
        return {g, a, f, im, mr, mw, sz, un, b, j, s, ca, fl, 1'b0};
    endfunction

    function automatic string tag_of(input logic [31:0] w);
        case (w[6:0])
            7'b0000011, 7'b0100011: return "R5";
            7'b1100011, 7'b1100111, 7'b1101111: return "R6";
            7'b0110011: return "R2";
            7'b0010011: return "R3";
            7'b1110011: return "R7";
            7'b0001011: return "R9";
            7'b0001111: return "R10";
            7'b0110111, 7'b0010111: return "R12";
            default: return "R1";
        endcase
    endfunction

    task automatic chk(input logic [31:0] w, input logic p, input string tag);
        logic [69:0] got, exp;
        @(posedge clk);
        insn = w;
        priv = p;
        @(negedge clk);
        got = {grp_o, alu_op_o, imm_fmt_o, imm_o, mem_rd_o, mem_wr_o, mem_size_o,
               mem_uns_o, br_o, jump_o, sys_o, csr_addr_o, tlb_flush_o, illegal_o};
        exp = model(w, p);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s insn=%h priv=%0d got=%h exp=%h", tag, w, p, got, exp);
        end
        if ({rd_o, rs1_o, rs2_o} !== {w[11:7], w[19:15], w[24:20]}) begin
            n_bad++;
            $display("FAIL R13 insn=%h got=%h exp=%h", w, {rd_o, rs1_o, rs2_o},
                     {w[11:7], w[19:15], w[24:20]});
        end
    endtask

    localparam logic [6:0] OPS [12] = '{7'b0000011, 7'b0001111, 7'b0010011, 7'b0010111,
        7'b0100011, 7'b0110011, 7'b0110111, 7'b1100011, 7'b1100111, 7'b1101111,
        7'b1110011, 7'b0001011};

    initial begin
        repeat (2000000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired got=running exp=finished");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        logic [31:0] w;
        void'($urandom(32'd4242));
        repeat (3) @(posedge clk);
        @(negedge clk);
        n_chk++; // reset state: all-zero word is illegal and idle (R1, R11)
        if (illegal_o !== 1'b1 || grp_o !== 4'd0 || imm_o !== 32'h0) begin
            n_bad++;
            $display("FAIL R11 reset got=%b/%h exp=1/0", illegal_o, imm_o);
        end
        rst_n = 1'b1;
        // directed corners
        chk(32'h0000_0073, 1'b0, "R7");
        chk(32'h0010_0073, 1'b0, "R7");
        chk(32'h0010_0173, 1'b1, "R7");
        chk(32'h1020_0073, 1'b0, "R8");
        chk(32'h1020_0073, 1'b1, "R8");
        chk(32'h1030_0073, 1'b1, "R7");
        chk(32'h3052_9073, 1'b0, "R8");
        chk(32'h8002_A073, 1'b1, "R7");
        chk(32'h0000_5073, 1'b1, "R7");
        chk(32'hFE00_100B, 1'b0, "R8");
        chk(32'hFE00_100B, 1'b1, "R9");
        chk(32'hFE00_008B, 1'b0, "R9");
        chk(32'h0000_300B, 1'b1, "R9");
        chk(32'h0000_100F, 1'b0, "R10");
        chk(32'h0000_200F, 1'b1, "R10");
        chk(32'h0230_0033, 1'b1, "R2");
        chk(32'h4020_80B3, 1'b1, "R2");
        chk(32'h4030_D093, 1'b1, "R3");
        chk(32'h0200_9093, 1'b1, "R3");
        chk(32'hFFF0_0093, 1'b0, "R4");
        chk(32'hFE00_8FA3, 1'b0, "R4");
        chk(32'hFE00_0EE3, 1'b0, "R4");
        chk(32'hFFFF_F0EF, 1'b0, "R4");
        chk(32'h8000_02B7, 1'b0, "R12");
        chk(32'h0000_6003, 1'b0, "R5");
        chk(32'h0000_2063, 1'b0, "R6");
        chk(32'h0000_1067, 1'b0, "R6");
        chk(32'h0000_0001, 1'b1, "R1");
        chk(32'h0000_0053, 1'b1, "R11");
        // constrained random
        for (int i = 0; i < 4000; i++) begin
            w = $urandom;
            if ($urandom_range(0, 7) != 0) begin
                w[6:0] = OPS[$urandom_range(0, 11)];
                case ($urandom_range(0, 3))
                    0: w[31:25] = 7'h00;
                    1: w[31:25] = 7'h20;
                    2: w[31:25] = 7'h01;
                    default: ;
                endcase
            end
            chk(w, 1'($urandom_range(0, 1)), tag_of(w));
        end
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule